// File: doc/BRIEF.md
# Printer Port Register Handshake Model

This block is a byte-wide printer port peripheral on a simple synchronous register bus. Software reaches three registers (data, status and control) through the low three bits of the access address. The block does not drive a real printer. It plays the printer's side of the handshake itself. Raising the strobe bit in the control register hands the latched data byte to an output byte stream. Later polls of the status register step the acknowledge and busy bits through a fixed sequence, so a polling driver runs to completion.

A level interrupt can be armed through the control register. It is raised when software drops strobe while the port is selected and out of init. The interrupt is cleared when the status register is read. When the direction bit is set, an external byte input is sampled every cycle into an input latch, and a data read returns that latch instead of the written byte.

Top module: `prn_port_top`

## Requirements
- R1: Only address bits [2:0] are decoded. Offset 0 is data, 1 is status and 2 is control. A read of offsets 3 to 7 returns 8'hFF, and a write to them changes no register.
- R2: Every control write stores the written byte with bits 7 and 6 forced to 1. A control read returns the stored byte.
- R3: A control write with bit 2 (init) = 0 loads status with 8'hD8. This sets bit 7 (not-busy), bit 6 (ack), bit 4 (online) and bit 3 (not-error), and clears the other bits.
- R4: A control write with bit 2 = 1, bit 3 (select) = 1 and bit 0 (strobe) = 1 clears status bit 7. If the previously stored strobe bit was 0, the current data byte appears on `out_byte` with `out_valid` high for exactly one cycle.
- R5: A control write with bit 2 = 1, bit 3 = 1 and bit 0 = 0 sets the interrupt pending state if the previously stored control bit 4 (interrupt enable) was 1.
- R6: A status read returns the stored status and clears the pending state. If status bit 7 is 0 and the stored strobe is 0, the read then updates status in one of two ways. If bit 6 was 1, it clears bit 6. If bit 6 was 0, it sets bits 6 and 7.
- R7: A data read returns the input latch when control bit 5 (direction) is 1, and the last written data byte otherwise.
- R8: While the stored direction bit is 1, the input latch is loaded from `pin_din` on every clock.
- R9: After reset both data latches are 8'hFF, status is 8'hD9, control is 8'hCC, `irq` is 0 and `rdata` is 8'hFF.
- R10: `irq` is a registered level equal to the pending state, updated on the clock edge of the access that changes it. `rdata` is valid on the cycle after a read and holds its value when no read takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Access request this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Access address; only bits [2:0] decoded |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pin_din | input | 8 | External byte sampled while direction = 1 |
| out_byte | output | 8 | Byte handed to the output stream |
| out_valid | output | 1 | One-cycle pulse marking a new `out_byte` |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that at most one access arrives per cycle and that `sel`, `we`, `addr` and `wdata` are known whenever `sel` is high. The interrupt and emit properties rely on this, because they trace each event back to the single access of the previous cycle. The stimulus drives a single access per cycle from tasks on the falling edge. Between accesses it idles `sel` low, and it keeps `pin_din` stable around every read made while the direction bit is set.

// File: rtl/prn_port_pkg.sv
package prn_port_pkg;
  localparam int BYTE_W = 8;
  localparam int DEC_W  = 3;

  localparam logic [DEC_W-1:0] OFS_DATA = 3'd0;
  localparam logic [DEC_W-1:0] OFS_STAT = 3'd1;
  localparam logic [DEC_W-1:0] OFS_CTRL = 3'd2;

  // status bit positions
  localparam int ST_NBUSY  = 7;
  localparam int ST_ACK    = 6;
  localparam int ST_ONLINE = 4;
  localparam int ST_NERR   = 3;
  localparam int ST_TMO    = 0;

  // control bit positions
  localparam int CT_DIR  = 5;
  localparam int CT_IEN  = 4;
  localparam int CT_SEL  = 3;
  localparam int CT_INIT = 2;
  localparam int CT_STB  = 0;

  localparam logic [BYTE_W-1:0] CTRL_FORCE = 8'hC0;
  localparam logic [BYTE_W-1:0] CTRL_RST   = 8'hCC;
  localparam logic [BYTE_W-1:0] STAT_INIT  =
    (8'h1 << ST_NBUSY) | (8'h1 << ST_ACK) | (8'h1 << ST_ONLINE) | (8'h1 << ST_NERR);
  localparam logic [BYTE_W-1:0] STAT_RST   = STAT_INIT | (8'h1 << ST_TMO);
  localparam logic [BYTE_W-1:0] DATA_RST   = 8'hFF;
  localparam logic [BYTE_W-1:0] UNMAPPED   = 8'hFF;

  typedef enum logic [1:0] {
    TGT_NONE,
    TGT_DATA,
    TGT_STAT,
    TGT_CTRL
  } reg_tgt_e;

  typedef struct packed {
    logic     rd;
    logic     wr;
    reg_tgt_e tgt;
  } access_t;
endpackage

// File: rtl/prn_decode.sv
module prn_decode
  import prn_port_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output access_t           acc
);
  logic [DEC_W-1:0] ofs;

  assign ofs = addr[DEC_W-1:0];

  always_comb begin
    acc.rd = sel & ~we;
    acc.wr = sel & we;
    unique case (ofs)
      OFS_DATA: acc.tgt = TGT_DATA;
      OFS_STAT: acc.tgt = TGT_STAT;
      OFS_CTRL: acc.tgt = TGT_CTRL;
      default:  acc.tgt = TGT_NONE;
    endcase
  end
endmodule

// File: rtl/prn_data_latch.sv
module prn_data_latch
  import prn_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  access_t           acc,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] pin_din,
  input  logic              dir_in,
  output logic [BYTE_W-1:0] data_w_q,
  output logic [BYTE_W-1:0] data_r_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_w_q <= DATA_RST;
      data_r_q <= DATA_RST;
    end else begin
      if (acc.wr && acc.tgt == TGT_DATA) data_w_q <= wdata;
      if (dir_in) data_r_q <= pin_din;
    end
  end
endmodule

// File: rtl/prn_handshake.sv
module prn_handshake
  import prn_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  access_t           acc,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] data_w,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic [BYTE_W-1:0] stat_q,
  output logic              pend_q,
  output logic              emit_v_q,
  output logic [BYTE_W-1:0] emit_b_q
);
  logic [BYTE_W-1:0] ctrl_new;
  logic              ctrl_wr, stat_rd;
  logic              arm;

  assign ctrl_new = wdata | CTRL_FORCE;
  assign ctrl_wr  = acc.wr && acc.tgt == TGT_CTRL;
  assign stat_rd  = acc.rd && acc.tgt == TGT_STAT;
  assign arm      = ctrl_new[CT_INIT] & ctrl_new[CT_SEL];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= CTRL_RST;
      stat_q   <= STAT_RST;
      pend_q   <= 1'b0;
      emit_v_q <= 1'b0;
      emit_b_q <= '0;
    end else begin
      emit_v_q <= 1'b0;
      if (ctrl_wr) begin
        ctrl_q <= ctrl_new;
        if (!ctrl_new[CT_INIT]) begin
          stat_q <= STAT_INIT;
        end else if (arm && ctrl_new[CT_STB]) begin
          stat_q[ST_NBUSY] <= 1'b0;
          if (!ctrl_q[CT_STB]) begin
            emit_v_q <= 1'b1;
            emit_b_q <= data_w;
          end
        end else if (arm && ctrl_q[CT_IEN]) begin
          pend_q <= 1'b1;
        end
      end else if (stat_rd) begin
        pend_q <= 1'b0;
        if (!stat_q[ST_NBUSY] && !ctrl_q[CT_STB]) begin
          if (stat_q[ST_ACK]) begin
            stat_q[ST_ACK] <= 1'b0;
          end else begin
            stat_q[ST_ACK]   <= 1'b1;
            stat_q[ST_NBUSY] <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/prn_port_top.sv
module prn_port_top
  import prn_port_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [7:0]        pin_din,
  output logic [7:0]        out_byte,
  output logic              out_valid,
  output logic              irq
);
  access_t           acc;
  logic [BYTE_W-1:0] data_w, data_r, ctrl, stat;
  logic [BYTE_W-1:0] rd_mux;

  prn_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sel  (sel),
    .we   (we),
    .addr (addr),
    .acc  (acc)
  );

  prn_data_latch u_data (
    .clk      (clk),
    .rst      (rst),
    .acc      (acc),
    .wdata    (wdata),
    .pin_din  (pin_din),
    .dir_in   (ctrl[CT_DIR]),
    .data_w_q (data_w),
    .data_r_q (data_r)
  );

  prn_handshake u_hs (
    .clk      (clk),
    .rst      (rst),
    .acc      (acc),
    .wdata    (wdata),
    .data_w   (data_w),
    .ctrl_q   (ctrl),
    .stat_q   (stat),
    .pend_q   (irq),
    .emit_v_q (out_valid),
    .emit_b_q (out_byte)
  );

  always_comb begin
    unique case (acc.tgt)
      TGT_DATA: rd_mux = ctrl[CT_DIR] ? data_r : data_w;
      TGT_STAT: rd_mux = stat;
      TGT_CTRL: rd_mux = ctrl;
      default:  rd_mux = UNMAPPED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= UNMAPPED;
    else if (acc.rd) rdata <= rd_mux;
  end
endmodule

// File: rtl/prn_port_checker.sv
module prn_port_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              sel,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic              out_valid,
  input logic              irq
);
  logic rd_now, ctrl_wr_now, stat_rd_now, unm_rd_now, ctrl_rd_now;
  assign rd_now      = sel && !we;
  assign ctrl_wr_now = sel && we && addr[2:0] == 3'd2;
  assign stat_rd_now = rd_now && addr[2:0] == 3'd1;
  assign ctrl_rd_now = rd_now && addr[2:0] == 3'd2;
  assign unm_rd_now  = rd_now && addr[2:0] > 3'd2;

  AST_UNMAPPED_FF: assert property (@(posedge clk) disable iff (rst)
    unm_rd_now |=> rdata == 8'hFF); // R1
  AST_CTRL_TOP_ONES: assert property (@(posedge clk) disable iff (rst)
    ctrl_rd_now |=> rdata[7:6] == 2'b11); // R2
  AST_EMIT_FROM_STROBE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(ctrl_wr_now && wdata[3:2] == 2'b11 && wdata[0])); // R4
  AST_EMIT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R4
  AST_IRQ_RISE_SRC: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(ctrl_wr_now && wdata[3:2] == 2'b11 && !wdata[0])); // R5
  AST_IRQ_CLR_ON_POLL: assert property (@(posedge clk) disable iff (rst)
    stat_rd_now |=> !irq); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_now |=> $stable(rdata)); // R10
endmodule

bind prn_port_top prn_port_checker #(.ADDR_W(ADDR_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .sel       (sel),
  .we        (we),
  .addr      (addr),
  .wdata     (wdata),
  .rdata     (rdata),
  .out_valid (out_valid),
  .irq       (irq)
);

// File: tb/test_prn_port_top.sv
module test_prn_port_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       sel, we;
  logic [7:0] addr, wdata, pin_din;
  logic [7:0] rdata, out_byte;
  logic       out_valid, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // behavioural reference state
  byte unsigned m_dw, m_dr, m_st, m_ct, m_rd, m_ob;
  bit m_irq, m_ov;
  byte unsigned emitted[$];

  always #2.5 clk = ~clk;

  prn_port_top #(.ADDR_W(8)) i_prn_port_top (
    .clk(clk), .rst(rst), .sel(sel), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_din(pin_din), .out_byte(out_byte),
    .out_valid(out_valid), .irq(irq)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_dw = 8'hFF; m_dr = 8'hFF; m_st = 8'hD9; m_ct = 8'hCC;
    m_rd = 8'hFF; m_irq = 0; m_ov = 0; m_ob = 0;
  endtask

  // advance the reference by one clock given the access sampled at that edge
  task automatic model_step(bit s, bit w, byte unsigned a, byte unsigned d, byte unsigned din);
    byte unsigned o_ct = m_ct;
    byte unsigned o_st = m_st;
    byte unsigned o_dr = m_dr;
    int ofs = a % 8;
    m_ov = 0;
    if (o_ct & 8'h20) m_dr = din;
    if (s && w) begin
      if (ofs == 0) m_dw = d;
      else if (ofs == 2) begin
        byte unsigned nv = d | 8'hC0;
        if ((nv & 8'h04) == 0) m_st = 8'hD8;
        else if (nv & 8'h08) begin
          if (nv & 8'h01) begin
            m_st = o_st & 8'h7F;
            if ((o_ct & 8'h01) == 0) begin m_ov = 1; m_ob = m_dw; emitted.push_back(m_dw); end
          end else if (o_ct & 8'h10) m_irq = 1;
        end
        m_ct = nv;
      end
    end else if (s) begin
      case (ofs)
        0: m_rd = (o_ct & 8'h20) ? o_dr : m_dw;
        1: begin
          m_rd = o_st; m_irq = 0;
          if ((o_st & 8'h80) == 0 && (o_ct & 8'h01) == 0) begin
            if (o_st & 8'h40) m_st = o_st & 8'hBF;
            else m_st = o_st | 8'hC0;
          end
        end
        2: m_rd = o_ct;
        default: m_rd = 8'hFF;
      endcase
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "rdata", rdata, m_rd);
    chk("R10", "irq", irq, m_irq);
    chk("R4", "out_valid", out_valid, m_ov);
    if (m_ov) chk("R4", "out_byte", out_byte, m_ob);
  endtask

  task automatic cyc(string tag, bit s, bit w, byte unsigned a, byte unsigned d);
    sel = s; we = w; addr = a; wdata = d;
    @(posedge clk);
    model_step(s, w, a, d, pin_din);
    @(negedge clk);
    compare(tag);
    sel = 0;
  endtask

  task automatic wr(string tag, byte unsigned a, byte unsigned d);
    cyc(tag, 1, 1, a, d);
    cyc(tag, 0, 0, 0, 0);
  endtask

  task automatic rd(string tag, byte unsigned a);
    cyc(tag, 1, 0, a, 0);
  endtask

  initial begin
    sel = 0; we = 0; addr = 0; wdata = 0; pin_din = 8'h00; rst = 1;
    repeat (3) @(negedge clk);
    rst = 0; model_reset();
    compare("R9");
    rd("R9", 2); rd("R9", 1); rd("R9", 0);
    wr("R1", 3, 8'h00); rd("R1", 3); rd("R1", 7);
    rd("R1", 8'hFA);                       // aliases control
    wr("R7", 0, 8'h41); rd("R7", 0);
    wr("R2", 2, 8'h0C); rd("R2", 2);
    wr("R4", 2, 8'h0D);                    // emit 0x41
    rd("R6", 1);
    wr("R4", 2, 8'h0D);                    // no second emit
    wr("R6", 2, 8'h0C);
    rd("R6", 1); rd("R6", 1); rd("R6", 1);
    wr("R5", 2, 8'h1C); wr("R5", 2, 8'h1C); // second arms irq
    rd("R5", 2);
    rd("R6", 1);
    wr("R5", 2, 8'h3C);                    // strobe low, sets pend, dir on
    pin_din = 8'hA5;
    cyc("R8", 0, 0, 0, 0); cyc("R8", 0, 0, 0, 0);
    rd("R8", 0);
    pin_din = 8'h5A; cyc("R8", 0, 0, 0, 0);
    rd("R7", 8'h08);
    wr("R3", 2, 8'h08); rd("R3", 1); rd("R3", 2);
    for (int i = 0; i < 400; i++) begin
      byte unsigned a = byte'($urandom_range(0, 15));
      byte unsigned d = byte'($urandom);
      if (i % 4 == 0) pin_din = byte'($urandom);
      if ($urandom_range(0, 1)) wr("R1", a, d);
      else rd("R6", a);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); n_chk++; n_fail++;
        $display("FAIL R10 watchdog: actual 0 expected 1"); end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule